// File: doc/BRIEF.md
# Four-Digit Decimal Stopwatch Counter

This block keeps an elapsed-time count as decimal digits. Each digit is a 4-bit BCD value that runs 0 through 9 and then wraps, so the packed output reads as a decimal number and is never hexadecimal. A prescaler on the single system clock makes a one-cycle tick once every `PRESCALE_LEN` clock cycles. The default of 2^20 cycles gives roughly a hundredth of a second at common board clock rates. The digits change only on that tick.

The least significant digit advances on every tick. Each higher digit advances only when every digit below it reads 9, so carries pass up the chain in the same cycle. A run input freezes both the digits and the prescaler. A synchronous reset clears the whole count and the prescaler phase. Every register is clocked by the rising edge of the one system clock. Display drive and button conditioning are handled outside this block.

Top module: `bcd_stopwatch`

## Requirements
- R1: `count` packs `NUM_DIGITS` BCD digits, with digit i at bits [4i+3:4i] and digit 0 the least significant. After reset, no digit ever holds a value above 9.
- R2: On a tick, digit 0 goes from 9 to 0, and from any other value v to v+1.
- R3: On a tick on which every lower digit reads 9, a higher digit goes from 9 to 0, and from any other value v to v+1.
- R4: On a tick on which any lower digit is not 9, a higher digit keeps its value. Between ticks, all digits keep their values.
- R5: When every digit reads 9, the next tick makes the whole count zero.
- R6: A tick happens on every `PRESCALE_LEN`-th rising edge on which `run` is high. After reset, the first change of `count` follows the `PRESCALE_LEN`-th such edge.
- R7: A rising edge with `rst` high clears every digit and the prescaler phase, whatever the value of `run`.
- R8: While `run` is low and `rst` is low, `count` keeps its value and the prescaler phase does not advance. This means the cycles of a tick interval can be split across pauses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Count enable; low pauses both the prescaler and the digits |
| count | output | 4*NUM_DIGITS | Packed BCD digits, digit 0 in the low nibble |

## Verification
The bench builds the block with `PRESCALE_LEN` = 4 and the default four digits. With this short prescaler, the full 0000 to 9999 span and the rollover to 0000 fit in a few tens of thousands of cycles. It also makes pauses that split a tick interval, and resets that land in mid-interval, frequent enough to check cycle by cycle against a decimal-integer reference model. Keeping four digits means the two-, three- and four-level carry chains are all exercised.

// File: rtl/sw_pkg.sv
package sw_pkg;
   localparam int unsigned BCD_W   = 4;
   localparam int unsigned BCD_MAX = 9;

   typedef logic [BCD_W-1:0] bcd_t;

   function automatic bcd_t bcd_next(input bcd_t v);
      return (v == bcd_t'(BCD_MAX)) ? bcd_t'(0) : v + bcd_t'(1);
   endfunction
endpackage

// File: rtl/sw_tick_gen.sv
module sw_tick_gen #(
   parameter int unsigned PRESCALE_LEN = 1 << 20
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);
   if (PRESCALE_LEN < 1) begin : g_bad_len
      $error("sw_tick_gen: PRESCALE_LEN must be at least 1");
   end

   if (PRESCALE_LEN == 1) begin : g_direct
      // Every running cycle is a tick; no phase storage needed.
      assign tick = run;
   end else begin : g_counted
      localparam int unsigned CNT_W = $clog2(PRESCALE_LEN);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE_LEN - 1);

      logic [CNT_W-1:0] phase;
      logic             at_last;

      assign at_last = (phase == LAST);
      assign tick    = run && at_last;

      always_ff @(posedge clk) begin
         if (rst)
            phase <= '0;
         else if (run)
            phase <= at_last ? '0 : phase + 1'b1;
      end

      // R8
      phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
         !run |=> $stable(phase));

      // R6
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
         tick |=> !tick);

      // R6
      phase_range_chk: assert property (@(posedge clk) disable iff (rst)
         phase <= LAST);
   end
endmodule

// File: rtl/sw_bcd_digit.sv
module sw_bcd_digit
   import sw_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic inc,
   output bcd_t digit,
   output logic at_max
);
   bcd_t value;

   always_ff @(posedge clk) begin
      if (rst)
         value <= '0;
      else if (inc)
         value <= bcd_next(value);
   end

   assign digit  = value;
   assign at_max = (value == bcd_t'(BCD_MAX));

   // R1
   digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      value <= bcd_t'(BCD_MAX));

   // R4
   digit_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !inc |=> $stable(value));

   // R3
   digit_step_chk: assert property (@(posedge clk) disable iff (rst)
      (inc && value != bcd_t'(BCD_MAX)) |=> value == $past(value) + bcd_t'(1));

   // R2
   digit_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (inc && value == bcd_t'(BCD_MAX)) |=> value == bcd_t'(0));
endmodule

// File: rtl/bcd_stopwatch.sv
module bcd_stopwatch
   import sw_pkg::*;
#(
   parameter int unsigned NUM_DIGITS   = 4,
   parameter int unsigned PRESCALE_LEN = 1 << 20
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        run,
   output logic [BCD_W*NUM_DIGITS-1:0] count
);
   localparam int unsigned OUT_W = BCD_W * NUM_DIGITS;

   if (NUM_DIGITS < 1) begin : g_bad_digits
      $error("bcd_stopwatch: NUM_DIGITS must be at least 1");
   end

   logic                  tick;
   logic [NUM_DIGITS:0]   step_en;
   logic [NUM_DIGITS-1:0] nine;

   sw_tick_gen #(
      .PRESCALE_LEN (PRESCALE_LEN)
   ) i_tick (
      .clk  (clk),
      .rst  (rst),
      .run  (run),
      .tick (tick)
   );

   assign step_en[0] = tick;

   for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
      bcd_t val;

      sw_bcd_digit i_dig (
         .clk    (clk),
         .rst    (rst),
         .inc    (step_en[d]),
         .digit  (val),
         .at_max (nine[d])
      );

      // A digit advances only when the tick reaches it through all lower nines.
      assign step_en[d+1]          = step_en[d] && nine[d];
      assign count[BCD_W*d +: BCD_W] = val;
   end

   // R5
   rollover_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && (&nine)) |=> count == OUT_W'(0));

   // R8
   pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !run |=> $stable(count));

   // R7
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> count == OUT_W'(0));
endmodule

// File: tb/test_bcd_stopwatch.sv
`timescale 1ns/1ps
module test_bcd_stopwatch;
   localparam int NUM_DIGITS   = 4;
   localparam int PRESCALE_LEN = 4;
   localparam int OUT_W        = 4 * NUM_DIGITS;
   localparam int MODULUS      = 10000;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             run = 1'b0;
   logic [OUT_W-1:0] count;

   int checks = 0;
   int errors = 0;
   int m_phase = 0;
   int m_value = 0;
   bit done = 0;

   always #2 clk = ~clk;

   bcd_stopwatch #(
      .NUM_DIGITS   (NUM_DIGITS),
      .PRESCALE_LEN (PRESCALE_LEN)
   ) i_bcd_stopwatch (
      .clk   (clk),
      .rst   (rst),
      .run   (run),
      .count (count)
   );

   function automatic logic [OUT_W-1:0] to_bcd(input int v);
      logic [OUT_W-1:0] r = '0;
      int t = v;
      for (int k = 0; k < NUM_DIGITS; k++) begin
         r[4*k +: 4] = 4'(t % 10);
         t = t / 10;
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [OUT_W-1:0] exp);
      checks++;
      if (count !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, count, exp);
      end
   endtask

   // One clock: drive at negedge, model at posedge, compare at the next negedge.
   task automatic cyc(input logic r, input logic rn);
      rst = r;
      run = rn;
      @(posedge clk);
      if (r) begin
         m_phase = 0;
         m_value = 0;
      end else if (rn) begin
         if (m_phase == PRESCALE_LEN - 1) begin
            m_phase = 0;
            m_value = (m_value + 1) % MODULUS;
         end else begin
            m_phase = m_phase + 1;
         end
      end
      @(negedge clk);
      check("R2/R3/R4 per-cycle", to_bcd(m_value));
      checks++;
      for (int k = 0; k < NUM_DIGITS; k++) begin
         if (count[4*k +: 4] > 4'd9) begin
            errors++;
            $display("FAIL R1 digit %0d actual=%h expected<=9", k, count[4*k +: 4]);
         end
      end
   endtask

   initial begin
      logic [OUT_W-1:0] held;
      @(negedge clk);
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1);
      check("R7 reset state", '0);

      // R6: first change exactly after PRESCALE_LEN running edges
      for (int i = 0; i < PRESCALE_LEN - 1; i++) cyc(1'b0, 1'b1);
      check("R6 before first tick", '0);
      cyc(1'b0, 1'b1);
      check("R6 first tick", 16'h0001);

      // R2 and R3: carry from digit 0 into digit 1
      for (int i = 0; i < 9 * PRESCALE_LEN; i++) cyc(1'b0, 1'b1);
      check("R2/R3 first carry", 16'h0010);

      // R8: pause in the middle of a tick interval
      cyc(1'b0, 1'b1);
      held = count;
      for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0);
      check("R8 paused hold", held);
      for (int i = 0; i < PRESCALE_LEN - 2; i++) cyc(1'b0, 1'b1);
      check("R8 phase kept across pause", held);
      cyc(1'b0, 1'b1);
      check("R8 tick after resumed interval", 16'h0011);

      // Irregular run pattern
      for (int i = 0; i < 400; i++) cyc(1'b0, (i % 7) != 3);
      // R7: reset landing mid-interval, with run high
      cyc(1'b0, 1'b1);
      cyc(1'b1, 1'b1);
      check("R7 mid-interval reset", '0);
      for (int i = 0; i < PRESCALE_LEN - 1; i++) cyc(1'b0, 1'b1);
      check("R7 phase cleared", '0);
      cyc(1'b0, 1'b1);
      check("R7 first tick after reset", 16'h0001);

      // Run up to 9999, with periodic pauses
      for (int i = 0; i < 60000 && !(m_value == 9999 && m_phase == 0); i++)
         cyc(1'b0, (i % 11) != 5);
      check("R3 full carry reach", 16'h9999);
      for (int i = 0; i < PRESCALE_LEN - 1; i++) cyc(1'b0, 1'b1);
      check("R4 held before rollover", 16'h9999);
      cyc(1'b0, 1'b1);
      check("R5 rollover to zero", 16'h0000);
      for (int i = 0; i < PRESCALE_LEN; i++) cyc(1'b0, 1'b1);
      check("R5 count after rollover", 16'h0001);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule